// File: doc/BRIEF.md
# I2C Interrupt and Clock-Stretch Hold Controller

This block sits beside an I2C bus engine. It records the engine's bus events in sticky flags, masks those flags with software enables, and merges the enabled flags into one interrupt line. Some enabled events also force a clock-stretch hold, which keeps SCL low until software releases it. An acknowledge-time event forces the hold only when the engine sent an ACK.

The engine reports events as single-cycle strobes on an 8-bit vector. The vector uses the same bit layout as the enable and flag registers. A plain register port reaches three locations: the enable register, the flag register and the hold bit. The port has write strobe, 2-bit select, write data and combinational read data. There is no data stream here, so every pin is a plain control or status pin and nothing has valid/ready back-pressure.

Top module: `i2c_irq_hold_ctrl`

## Requirements
- R1: After reset, the enable register, the flag register, the hold bit and the interrupt output are all 0.
- R2: Select 0 holds the enable register. It is written with write data and read back unchanged, except that bit 5 always reads 0. Bit 7 is byte count, bit 6 is ack-time, bit 4 is data write, bit 3 is address, bit 2 is stop, bit 1 is restart and bit 0 is start.
- R3: A strobe on an event bit sets the matching flag (select 1) in the next cycle, whether or not that bit is enabled.
- R4: Writing 1 to a flag bit at select 1 clears that flag. Writing 0 leaves it unchanged.
- R5: When a strobe and a clear hit the same flag in the same cycle, the flag ends up set.
- R6: The interrupt output is high exactly when some flag is set and its enable bit is also set.
- R7: An ack-time strobe (bit 6) with its enable set and the ACK indicator at 1 sets the hold bit. With the indicator at 0 (NACK), the hold bit keeps its value.
- R8: A data-write strobe (bit 4) or an address strobe (bit 3) sets the hold bit when its enable is set.
- R9: Byte-count, stop, restart and start strobes never set the hold bit. Disabled strobes never set it either.
- R10: Writing 0 to bit 0 at select 2 clears the hold bit. A hold-causing strobe in the same cycle keeps the bit set. Writing 1 there has no effect.
- R11: A strobe on bit 5 and writes to bit 5 are ignored, and bit 5 always reads 0.
- R12: Select 3 reads 0. Select 2 reads the hold bit in bit 0, with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | One-cycle event strobes, same layout as the enable register |
| ack_sent_i | input | 1 | 1 = ACK sent, 0 = NACK, qualifies the ack-time strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 enable, 1 flags, 2 hold, 3 unused |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for the selected location |
| irq_o | output | 1 | Combined interrupt |
| hold_o | output | 1 | Clock-stretch hold bit |

## Verification
The assertions assume that `ack_sent_i` is valid in every cycle that carries an ack-time strobe. They also assume that several event strobes may rise together with a register write. The bench holds each stimulus for exactly one clock and then returns every input to idle. It changes inputs only on the falling edge, so each strobe lasts one cycle and every combination that occurs is one the properties cover. The bench deliberately places strobes in the same cycle as clears, to exercise the rule that a set wins over a clear.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int EVW     = 8;
  localparam int B_CNT   = 7;
  localparam int B_ACKT  = 6;
  localparam int B_RSVD  = 5;
  localparam int B_WR    = 4;
  localparam int B_ADR   = 3;
  localparam int B_STOP  = 2;
  localparam int B_RST   = 1;
  localparam int B_START = 0;
  localparam logic [EVW-1:0] LIVE_MASK = ~(EVW'(1) << B_RSVD);
  localparam logic [EVW-1:0] HOLD_PLAIN = (EVW'(1) << B_WR) | (EVW'(1) << B_ADR);

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_HOLD = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
  import i2c_irq_pkg::*;
#(
  parameter int W = EVW,
  parameter logic [W-1:0] LIVE = LIVE_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic unused_dead;
  assign unused_dead = ^((set_i | clr_i) & ~LIVE);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (set_i[i]) flag_q <= 1'b1;
        else if (clr_i[i]) flag_q <= 1'b0;
      end
      assign flag_o[i] = flag_q;

      // R3: strobe sets the flag
      a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> flag_o[i]);
      // R4: clear without strobe drops the flag
      a_r4_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    end else begin : g_dead
      assign flag_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_hold_ctrl.sv
module i2c_hold_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int W = EVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic         ack_sent_i,
  input  logic         release_i,
  output logic         hold_o
);
  logic ack_hit, plain_hit, hold_set, hold_q;
  logic unused_evt;
  assign unused_evt = ^(evt_i & ~(HOLD_PLAIN | (W'(1) << B_ACKT)));

  assign ack_hit   = evt_i[B_ACKT] && en_i[B_ACKT] && ack_sent_i;
  assign plain_hit = |(evt_i & en_i & HOLD_PLAIN);
  assign hold_set  = ack_hit || plain_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= 1'b0;
    else if (hold_set)  hold_q <= 1'b1;
    else if (release_i) hold_q <= 1'b0;
  end
  assign hold_o = hold_q;

  a_r7_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[B_ACKT] && en_i[B_ACKT] && ack_sent_i) |=> hold_o);
  a_r7_nack_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[B_ACKT] && !ack_sent_i && !plain_hit && !release_i) |=> (hold_o == $past(hold_o)));
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[B_WR] && en_i[B_WR]) |=> hold_o);
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !hold_set) |=> !hold_o);
  a_r9_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_o && !(|(evt_i & en_i & (HOLD_PLAIN | (W'(1) << B_ACKT))))) |=> !hold_o);
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
  import i2c_irq_pkg::*;
#(
  parameter int W = EVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] flag_i,
  input  logic         hold_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] flag_clr_o,
  output logic         hold_rel_o,
  output logic [W-1:0] rdata_o
);
  reg_sel_e   sel;
  logic [W-1:0] en_q;
  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    en_q <= '0;
    else if (wr_i && sel == SEL_EN) en_q <= wdata_i & LIVE_MASK;
  end
  assign en_o = en_q;

  assign flag_clr_o = (wr_i && sel == SEL_FLAG) ? wdata_i : '0;
  assign hold_rel_o = wr_i && sel == SEL_HOLD && !wdata_i[0];

  always_comb begin
    unique case (sel)
      SEL_EN:   rdata_o = en_q;
      SEL_FLAG: rdata_o = flag_i;
      SEL_HOLD: rdata_o = {{(W-1){1'b0}}, hold_i};
      default:  rdata_o = '0;
    endcase
  end

  // R11: reserved enable bit never holds a 1
  a_r11_rsvd_en: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel == SEL_EN) |=> !en_o[B_RSVD]);
endmodule

// File: rtl/i2c_irq_hold_ctrl.sv
module i2c_irq_hold_ctrl
  import i2c_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_i,
  input  logic       ack_sent_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  output logic       hold_o
);
  logic [EVW-1:0] en, flags, flag_clr;
  logic           hold_rel, hold;

  i2c_irq_regs #(.W(EVW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .flag_i(flags), .hold_i(hold),
    .en_o(en), .flag_clr_o(flag_clr), .hold_rel_o(hold_rel), .rdata_o(reg_rdata_o)
  );

  i2c_evt_flags #(.W(EVW), .LIVE(LIVE_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(flag_clr), .flag_o(flags)
  );

  i2c_hold_ctrl #(.W(EVW)) u_hold (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_i(en),
    .ack_sent_i(ack_sent_i), .release_i(hold_rel), .hold_o(hold)
  );

  assign irq_o  = |(flags & en);
  assign hold_o = hold;

  // R6: no enables means no interrupt
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_o);
  // R5: set wins over a same-cycle clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[B_START] && flag_clr[B_START]) |=> flags[B_START]);
endmodule

// File: tb/i2c_irq_hold_ctrl_tb.sv
module i2c_irq_hold_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic       ack = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, hold;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_hold_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ack_sent_i(ack),
    .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .hold_o(hold)
  );

  // {req[4], evt[8], ack, wr, sel[2], wdata[8], exp_flags[8], 2'b0, exp_irq, exp_hold}
  localparam logic [35:0] TBL [0:15] = '{
    {4'd1,  8'h00, 1'b0, 1'b1, 2'd0, 8'h00, 8'h00, 2'b0, 1'b0, 1'b0}, // R1 nothing enabled
    {4'd3,  8'h01, 1'b0, 1'b0, 2'd0, 8'h00, 8'h01, 2'b0, 1'b0, 1'b0}, // R3 flag while disabled
    {4'd6,  8'h00, 1'b0, 1'b1, 2'd0, 8'h01, 8'h01, 2'b0, 1'b1, 1'b0}, // R6 enable raises irq
    {4'd4,  8'h00, 1'b0, 1'b1, 2'd1, 8'h01, 8'h00, 2'b0, 1'b0, 1'b0}, // R4 w1c
    {4'd2,  8'h00, 1'b0, 1'b1, 2'd0, 8'hFF, 8'h00, 2'b0, 1'b0, 1'b0}, // R2 all enables
    {4'd7,  8'h40, 1'b0, 1'b0, 2'd0, 8'h00, 8'h40, 2'b0, 1'b1, 1'b0}, // R7 nack no hold
    {4'd7,  8'h40, 1'b1, 1'b0, 2'd0, 8'h00, 8'h40, 2'b0, 1'b1, 1'b1}, // R7 ack holds
    {4'd10, 8'h00, 1'b0, 1'b1, 2'd2, 8'h00, 8'h40, 2'b0, 1'b1, 1'b0}, // R10 release
    {4'd4,  8'h00, 1'b0, 1'b1, 2'd1, 8'h40, 8'h00, 2'b0, 1'b0, 1'b0}, // R4 clear ack flag
    {4'd8,  8'h10, 1'b0, 1'b0, 2'd0, 8'h00, 8'h10, 2'b0, 1'b1, 1'b1}, // R8 data write holds
    {4'd10, 8'h08, 1'b0, 1'b1, 2'd2, 8'h00, 8'h18, 2'b0, 1'b1, 1'b1}, // R10 R8 address beats release
    {4'd9,  8'h80, 1'b0, 1'b1, 2'd1, 8'h18, 8'h80, 2'b0, 1'b1, 1'b1}, // R9 count keeps hold
    {4'd10, 8'h00, 1'b0, 1'b1, 2'd2, 8'h00, 8'h80, 2'b0, 1'b1, 1'b0}, // R10 release
    {4'd9,  8'h86, 1'b1, 1'b0, 2'd0, 8'h00, 8'h86, 2'b0, 1'b1, 1'b0}, // R9 stop restart no hold
    {4'd4,  8'h00, 1'b0, 1'b1, 2'd1, 8'hFF, 8'h00, 2'b0, 1'b0, 1'b0}, // R4 clear all
    {4'd11, 8'h20, 1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 2'b0, 1'b0, 1'b0}  // R11 bit5 strobe ignored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] e, input logic a, input logic w,
                      input logic [1:0] s, input logic [7:0] d);
    evt = e; ack = a; wr = w; sel = s; wdata = d;
    @(posedge clk);
    @(negedge clk);
    evt = '0; ack = 1'b0; wr = 1'b0; sel = 2'd0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    sel = s;
    #1;
    v = rdata;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 enable", v, 8'h00);
    rd(2'd1, v); check("R1 flags", v, 8'h00);
    check("R1 irq/hold", {6'b0, irq, hold}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 16; k++) begin
      logic [35:0] t;
      string tag;
      t = TBL[k];
      step(t[31:24], t[23], t[22], t[21:20], t[19:12]);
      tag = $sformatf("R%0d vec%0d", t[35:32], k);
      rd(2'd1, v);
      check({tag, " flags"}, v, t[11:4]);
      check({tag, " irq"}, {7'b0, irq}, {7'b0, t[1]});
      check({tag, " hold"}, {7'b0, hold}, {7'b0, t[0]});
    end

    // R2 R11 readback: bit5 masked
    rd(2'd0, v); check("R2 R11 enable readback", v, 8'hDF);
    // R12 unused select and hold layout
    rd(2'd3, v); check("R12 select3", v, 8'h00);
    // R5 set wins over clear on same bit
    step(8'h01, 1'b0, 1'b0, 2'd0, 8'h00);
    step(8'h01, 1'b0, 1'b1, 2'd1, 8'h01);
    rd(2'd1, v); check("R5 set wins", v, 8'h01);
    // R10 writing 1 to hold has no effect
    step(8'h00, 1'b0, 1'b1, 2'd2, 8'hFF);
    check("R10 write1 ignored", {7'b0, hold}, 8'h00);
    // R9 disabled ack-time with ACK does not hold
    step(8'h00, 1'b0, 1'b1, 2'd0, 8'h01);
    step(8'h40, 1'b1, 1'b0, 2'd0, 8'h00);
    check("R9 disabled ackt", {7'b0, hold}, 8'h00);
    check("R6 ackt flag masked", {7'b0, irq}, 8'h01);
    // R12 hold read layout
    step(8'h10, 1'b0, 1'b1, 2'd0, 8'h10);
    step(8'h10, 1'b0, 1'b0, 2'd0, 8'h00);
    rd(2'd2, v); check("R12 hold read", v, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule